// File: doc/BRIEF.md
# Dual-Port Memory Write Permission Filter

This block sits in front of a word-organised non-volatile memory that can be written from two sides: a wired host port and a radio-command port. Every write request carries the port, the radio security state (open or secured), a word address, a length of zero to seven words and up to two data words. The block combines these with the currently stored control word, block-lock word and configuration word. One clock later it presents a decision: accept or reject, a reason code, the word address to commit at, and the exact words to commit. Those committed words may differ from the request data, because sticky and protected bits are merged in.

The two ports are deliberately treated unequally. Lock bits for user blocks 1 to 15 can only ever be added, never removed. The host may set or clear the block-0 lock and is not bound by it. Per-bank lock pairs restrict only radio writes. The device-address bits freeze once their lock bit is set. Calibration and identifier words are read-only to both ports. Configuration bits other than the two privacy bits can only be changed from the host.

Word map (word n holds host bytes 2n and 2n+1): words 0–1 kill password, 2–3 access password, 4 control word, 5–8 calibration, 9 block-lock word, 10 configuration, 11–19 identifier-code header and private code, 20–25 identifier, 26–31 public code, 32–543 user area, 544 and above unmapped.

Top module: `wperm_filter`

## Requirements
- R1: Each request presented with `req_valid` high produces, on the next rising edge, `dec_valid`=1 with its decision. `dec_addr` is the committed base word and `dec_two` is 1 for a two-word request. A cycle without a request produces all-zero outputs. Rejected requests output zero commit data. An accepted request has reason 0. Reason codes: 0 none, 1 locked block, 2 bank lock, 3 read-only region, 4 bad length or alignment, 5 radio block-lock command disabled.
- R2: User word u (word 32+u) belongs to block u/32 for u<128 and to block 4+(u−128)/8 for 128≤u<224. Words with u≥224 have no block. A write to a block whose bit is set in the block-lock word (bit i = block i) is rejected with reason 1.
- R3: The block-0 lock rejects radio writes but is ignored for host writes.
- R4: An accepted host write to word 9 commits the OR of old and new data in bits 15:1, and the new data unchanged in bit 0.
- R5: A radio write to word 9 is rejected with reason 5 when configuration bit 5 is 0. When that bit is 1, it commits the OR of old and new data in all 16 bits.
- R6: Control-word bit pairs {15:14} kill password, {13:12} access password, {11:10} words 11–19 and 26–31, and {9:8} user area gate radio writes. The pair values are 00 or 01 writable, 10 writable only when secured, and 11 never writable. A blocked write gets reason 2. Host writes ignore these pairs.
- R7: When control bit 7 is 1, an accepted host write to word 4 keeps the old bits 7 and 1:0 and takes the rest from the new data. When control bit 7 is 0, the data is committed as written.
- R8: Words 5–8, 20–25 and ≥544 are read-only for both ports, and word 4 is read-only for the radio. Each gives reason 3.
- R9: An accepted radio write to word 10 takes only bits 4:3 from the new data and keeps all other configuration bits.
- R10: Radio lengths: one word is accepted. Two words are accepted only at an even address. Two words at an odd address, or three or more words, give reason 4. Zero words give reason 4 with `dec_mute`=1 (no reply).
- R11: Host lengths of one or two words are valid, and a two-word request clears the address bit 0. Any other host length gives reason 4.
- R12: A two-word request is accepted only if both words pass. The reported reason is the first word's reason if that word fails, otherwise the second word's reason. A length error takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present this cycle |
| req_radio | input | 1 | 1 = radio port, 0 = host port |
| req_secured | input | 1 | Radio session is in the secured state |
| req_addr | input | ADDR_W | Requested word address |
| req_len | input | LEN_W | Number of words requested |
| req_data0 | input | 16 | First data word |
| req_data1 | input | 16 | Second data word |
| lock_word | input | 16 | Stored control word (word 4) |
| blk_word | input | 16 | Stored block-lock word (word 9) |
| cfg_word | input | 16 | Stored configuration word (word 10) |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Write may be committed |
| dec_mute | output | 1 | Radio request must get no reply |
| dec_reason | output | 3 | Reject reason code |
| dec_addr | output | ADDR_W | Base word address to commit |
| dec_two | output | 1 | Two words to commit |
| dec_data0 | output | 16 | Word to commit at `dec_addr` |
| dec_data1 | output | 16 | Word to commit at `dec_addr`+1 |

## Verification
Every result of this block is due exactly one rising edge after its request: one register stage sits between the request and stored-word inputs and all decision outputs. The bench drives a request on a falling edge. It compares all outputs at the next falling edge against a behavioural model evaluated on that same request, and it does this every cycle, including idle and reset cycles. Because the stored words are applied together with each request, no result depends on a value from two cycles back.

// File: rtl/wperm_pkg.sv
package wperm_pkg;
  localparam int DW = 16;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_BLOCK   = 3'd1,
    RSN_BANK    = 3'd2,
    RSN_RDONLY  = 3'd3,
    RSN_LENGTH  = 3'd4,
    RSN_LOCKOFF = 3'd5
  } reason_e;

  typedef enum logic [3:0] {
    RG_KPWD, RG_APWD, RG_CTRL, RG_CAL, RG_BLK, RG_CFG,
    RG_EPC, RG_IDENT, RG_EPCPUB, RG_USER, RG_NONE
  } region_e;

  // first word of each region
  localparam int W_APWD   = 2;
  localparam int W_CTRL   = 4;
  localparam int W_CAL    = 5;
  localparam int W_BLK    = 9;
  localparam int W_CFG    = 10;
  localparam int W_EPC    = 11;
  localparam int W_IDENT  = 20;
  localparam int W_EPCPUB = 26;
  localparam int W_USER   = 32;

  // control word: frozen bits once the address lock is set
  localparam logic [DW-1:0] CTRL_KEEP = 16'h0083;
  localparam int CTRL_ADRLOCK = 7;
  // configuration word: radio-writable privacy bits and block-lock enable
  localparam logic [DW-1:0] CFG_RADIO = 16'h0018;
  localparam int CFG_LOCKEN = 5;
endpackage

// File: rtl/wperm_region.sv
module wperm_region
  import wperm_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int USER_WORDS  = 512,
  parameter int BIG_WORDS   = 32,
  parameter int NUM_BIG     = 4,
  parameter int SMALL_WORDS = 8,
  parameter int NUM_SMALL   = 12,
  localparam int NUM_BLK    = NUM_BIG + NUM_SMALL,
  localparam int IDX_W      = $clog2(NUM_BLK)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              blk_hit,
  output logic [IDX_W-1:0]  blk_idx
);
  localparam logic [ADDR_W-1:0] A_APWD   = ADDR_W'(W_APWD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(W_CTRL);
  localparam logic [ADDR_W-1:0] A_BLK    = ADDR_W'(W_BLK);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(W_CFG);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(W_IDENT);
  localparam logic [ADDR_W-1:0] A_EPCPUB = ADDR_W'(W_EPCPUB);
  localparam logic [ADDR_W-1:0] A_USER   = ADDR_W'(W_USER);
  localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(W_USER + USER_WORDS);
  localparam logic [ADDR_W-1:0] BIG_SPAN = ADDR_W'(BIG_WORDS * NUM_BIG);
  localparam logic [ADDR_W-1:0] ALL_SPAN = ADDR_W'(BIG_WORDS * NUM_BIG + SMALL_WORDS * NUM_SMALL);

  logic [ADDR_W-1:0] u;

  always_comb begin
    if (addr < A_APWD)        region = RG_KPWD;
    else if (addr < A_CTRL)   region = RG_APWD;
    else if (addr == A_CTRL)  region = RG_CTRL;
    else if (addr < A_BLK)    region = RG_CAL;
    else if (addr == A_BLK)   region = RG_BLK;
    else if (addr == A_CFG)   region = RG_CFG;
    else if (addr < A_IDENT)  region = RG_EPC;
    else if (addr < A_EPCPUB) region = RG_IDENT;
    else if (addr < A_USER)   region = RG_EPCPUB;
    else if (addr < A_END)    region = RG_USER;
    else                      region = RG_NONE;
  end

  // user offset to lock-block index: large blocks first, then small ones
  always_comb begin
    u       = addr - A_USER;
    blk_hit = 1'b0;
    blk_idx = '0;
    if (region == RG_USER) begin
      if (u < BIG_SPAN) begin
        blk_hit = 1'b1;
        blk_idx = IDX_W'(u / ADDR_W'(BIG_WORDS));
      end else if (u < ALL_SPAN) begin
        blk_hit = 1'b1;
        blk_idx = IDX_W'(NUM_BIG) + IDX_W'((u - BIG_SPAN) / ADDR_W'(SMALL_WORDS));
      end
    end
  end
endmodule

// File: rtl/wperm_word.sv
module wperm_word
  import wperm_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int USER_WORDS  = 512,
  parameter int BIG_WORDS   = 32,
  parameter int NUM_BIG     = 4,
  parameter int SMALL_WORDS = 8,
  parameter int NUM_SMALL   = 12,
  localparam int IDX_W      = $clog2(NUM_BIG + NUM_SMALL)
) (
  input  logic              radio,
  input  logic              secured,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     lock_word,
  input  logic [DW-1:0]     blk_word,
  input  logic [DW-1:0]     cfg_word,
  output logic              ok,
  output reason_e           reason,
  output logic [DW-1:0]     commit
);
  region_e          rg;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       pair;
  logic             bank_ok;
  logic             blk_lock;

  wperm_region #(
    .ADDR_W(ADDR_W), .USER_WORDS(USER_WORDS), .BIG_WORDS(BIG_WORDS),
    .NUM_BIG(NUM_BIG), .SMALL_WORDS(SMALL_WORDS), .NUM_SMALL(NUM_SMALL)
  ) u_region (
    .addr(addr), .region(rg), .blk_hit(hit), .blk_idx(idx)
  );

  always_comb begin
    case (rg)
      RG_KPWD:           pair = lock_word[15:14];
      RG_APWD:           pair = lock_word[13:12];
      RG_EPC, RG_EPCPUB: pair = lock_word[11:10];
      RG_USER:           pair = lock_word[9:8];
      default:           pair = 2'b00;
    endcase
    bank_ok  = !pair[1] || (!pair[0] && secured);
    // block 0 binds only the radio side
    blk_lock = hit && blk_word[idx] && (radio || idx != '0);
  end

  always_comb begin
    ok     = 1'b1;
    reason = RSN_NONE;
    commit = wdata;
    if (radio) begin
      case (rg)
        RG_CAL, RG_IDENT, RG_NONE, RG_CTRL: begin
          ok = 1'b0; reason = RSN_RDONLY;
        end
        RG_BLK: begin
          if (!cfg_word[CFG_LOCKEN]) begin
            ok = 1'b0; reason = RSN_LOCKOFF;
          end else begin
            commit = blk_word | wdata;
          end
        end
        RG_CFG: commit = (cfg_word & ~CFG_RADIO) | (wdata & CFG_RADIO);
        default: begin
          if (!bank_ok) begin
            ok = 1'b0; reason = RSN_BANK;
          end else if (blk_lock) begin
            ok = 1'b0; reason = RSN_BLOCK;
          end
        end
      endcase
    end else begin
      case (rg)
        RG_CAL, RG_IDENT, RG_NONE: begin
          ok = 1'b0; reason = RSN_RDONLY;
        end
        RG_CTRL: if (lock_word[CTRL_ADRLOCK])
                   commit = (wdata & ~CTRL_KEEP) | (lock_word & CTRL_KEEP);
        RG_BLK:  commit = ((blk_word | wdata) & 16'hFFFE) | (wdata & 16'h0001);
        RG_USER: if (blk_lock) begin
                   ok = 1'b0; reason = RSN_BLOCK;
                 end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wperm_filter.sv
module wperm_filter
  import wperm_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LEN_W       = 3,
  parameter int USER_WORDS  = 512,
  parameter int BIG_WORDS   = 32,
  parameter int NUM_BIG     = 4,
  parameter int SMALL_WORDS = 8,
  parameter int NUM_SMALL   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_radio,
  input  logic              req_secured,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [15:0]       req_data0,
  input  logic [15:0]       req_data1,
  input  logic [15:0]       lock_word,
  input  logic [15:0]       blk_word,
  input  logic [15:0]       cfg_word,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_mute,
  output logic [2:0]        dec_reason,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              dec_two,
  output logic [15:0]       dec_data0,
  output logic [15:0]       dec_data1
);
  localparam int LANES = 2;

  logic              two, len_ok, mute, accept;
  logic [ADDR_W-1:0] base;
  reason_e           rsn;
  logic [ADDR_W-1:0] lane_a  [LANES];
  logic [DW-1:0]     lane_d  [LANES];
  logic [DW-1:0]     lane_c  [LANES];
  logic              lane_ok [LANES];
  reason_e           lane_r  [LANES];

  assign two    = (req_len == LEN_W'(2));
  assign base   = (two && !req_radio) ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
  assign len_ok = req_radio ? ((req_len == LEN_W'(1)) || (two && !req_addr[0]))
                            : ((req_len == LEN_W'(1)) || two);
  assign mute   = req_radio && (req_len == '0);
  assign lane_d[0] = req_data0;
  assign lane_d[1] = req_data1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_a[k] = base + ADDR_W'(k);
    wperm_word #(
      .ADDR_W(ADDR_W), .USER_WORDS(USER_WORDS), .BIG_WORDS(BIG_WORDS),
      .NUM_BIG(NUM_BIG), .SMALL_WORDS(SMALL_WORDS), .NUM_SMALL(NUM_SMALL)
    ) u_word (
      .radio(req_radio), .secured(req_secured), .addr(lane_a[k]),
      .wdata(lane_d[k]), .lock_word(lock_word), .blk_word(blk_word),
      .cfg_word(cfg_word), .ok(lane_ok[k]), .reason(lane_r[k]),
      .commit(lane_c[k])
    );
  end

  // lowest failing lane wins; length error overrides all lanes
  always_comb begin
    rsn = RSN_NONE;
    for (int k = LANES - 1; k >= 0; k--)
      if ((k < int'(req_len)) && !lane_ok[k]) rsn = lane_r[k];
    if (!len_ok) rsn = RSN_LENGTH;
    accept = req_valid && (rsn == RSN_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_mute   <= 1'b0;
      dec_reason <= '0;
      dec_addr   <= '0;
      dec_two    <= 1'b0;
      dec_data0  <= '0;
      dec_data1  <= '0;
    end else begin
      dec_valid  <= 1'b1;
      dec_accept <= accept;
      dec_mute   <= mute;
      dec_reason <= rsn;
      dec_addr   <= base;
      dec_two    <= two;
      dec_data0  <= accept ? lane_c[0] : '0;
      dec_data1  <= (accept && two) ? lane_c[1] : '0;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid && !dec_accept);
  assert_accept_clean_R1: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid && dec_reason == 3'd0 && !dec_mute);
  assert_blk_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    dec_accept && dec_addr == ADDR_W'(W_BLK) && !$past(req_radio)
    |-> (dec_data0[15:1] & $past(blk_word[15:1])) == $past(blk_word[15:1]));
  assert_lockoff_R5: assert property (@(posedge clk) disable iff (rst)
    dec_valid && $past(req_radio) && dec_addr == ADDR_W'(W_BLK) && !$past(cfg_word[CFG_LOCKEN])
    |-> !dec_accept);
  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    dec_accept && dec_addr == ADDR_W'(W_CTRL) && $past(lock_word[CTRL_ADRLOCK])
    |-> dec_data0[CTRL_ADRLOCK] && dec_data0[1:0] == $past(lock_word[1:0]));
  assert_cfg_hostonly_R9: assert property (@(posedge clk) disable iff (rst)
    dec_accept && $past(req_radio) && dec_addr == ADDR_W'(W_CFG)
    |-> dec_data0[2:0] == $past(cfg_word[2:0]) && dec_data0[15:5] == $past(cfg_word[15:5]));
  assert_mute_R10: assert property (@(posedge clk) disable iff (rst)
    dec_mute |-> !dec_accept && $past(req_radio) && $past(req_len) == '0);
endmodule

// File: tb/sim_wperm_filter.sv
`timescale 1ns/1ps
module sim_wperm_filter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        req_valid, req_radio, req_secured;
  logic [9:0]  req_addr;
  logic [2:0]  req_len;
  logic [15:0] req_data0, req_data1, lock_word, blk_word, cfg_word;
  logic        dec_valid, dec_accept, dec_mute, dec_two;
  logic [2:0]  dec_reason;
  logic [9:0]  dec_addr;
  logic [15:0] dec_data0, dec_data1;

  wperm_filter u0 (.*);

  int vec = 0, bad = 0;
  bit done = 0;
  logic [15:0] p_lw = 0, p_bw = 0, p_cw = 0;
  logic        e_valid = 0, e_acc = 0, e_mute = 0, e_two = 0;
  logic [2:0]  e_rsn = 0;
  logic [9:0]  e_addr = 0;
  logic [15:0] e_d0 = 0, e_d1 = 0;
  string       e_tag = "R1";

  function automatic void ref_word(input bit rad, input bit sec, input int w,
      input logic [15:0] d, lw, bw, cw, output int rsn, output logic [15:0] c);
    int pair = -1, blk = -1, u;
    bit ro;
    c = d; rsn = 0;
    if (w < 2) pair = int'(lw[15:14]);
    else if (w < 4) pair = int'(lw[13:12]);
    else if ((w >= 11 && w < 20) || (w >= 26 && w < 32)) pair = int'(lw[11:10]);
    else if (w >= 32 && w < 544) pair = int'(lw[9:8]);
    if (w >= 32 && w < 544) begin
      u = w - 32;
      if (u < 128) blk = u / 32;
      else if (u < 224) blk = 4 + (u - 128) / 8;
    end
    ro = (w >= 5 && w <= 8) || (w >= 20 && w < 26) || w >= 544 || (rad && w == 4);
    if (ro) rsn = 3;
    else if (w == 9) begin
      if (rad) begin
        if (!cw[5]) rsn = 5; else c = bw | d;
      end else c = ((bw | d) & 16'hFFFE) | (d & 16'h0001);
    end else if (w == 10) begin
      if (rad) c = (cw & 16'hFFE7) | (d & 16'h0018);
    end else if (w == 4) begin
      if (lw[7]) c = (d & 16'hFF7C) | (lw & 16'h0083);
    end else begin
      if (rad && (pair == 3 || (pair == 2 && !sec))) rsn = 2;
      else if (blk >= 0 && bw[blk] && (rad || blk != 0)) rsn = 1;
    end
  endfunction

  task automatic check_now();
    vec++;
    if ({dec_valid, dec_accept, dec_mute, dec_reason, dec_addr, dec_two, dec_data0, dec_data1} !==
        {e_valid, e_acc, e_mute, e_rsn, e_addr, e_two, e_d0, e_d1}) begin
      bad++;
      $display("FAIL %s: got v=%0b a=%0b m=%0b r=%0d ad=%0d t=%0b d=%h/%h exp v=%0b a=%0b m=%0b r=%0d ad=%0d t=%0b d=%h/%h",
        e_tag, dec_valid, dec_accept, dec_mute, dec_reason, dec_addr, dec_two, dec_data0, dec_data1,
        e_valid, e_acc, e_mute, e_rsn, e_addr, e_two, e_d0, e_d1);
    end
  endtask

  task automatic apply(input string tag, input bit v, input bit rad, input bit sec,
                       input int a, input int len, input logic [15:0] d0, input logic [15:0] d1);
    int r0, r1, rsn, base;
    logic [15:0] c0, c1;
    bit two, lenok, acc;
    @(negedge clk);
    check_now();
    req_valid = v; req_radio = rad; req_secured = sec; req_addr = a[9:0];
    req_len = len[2:0]; req_data0 = d0; req_data1 = d1;
    lock_word = p_lw; blk_word = p_bw; cfg_word = p_cw;
    e_tag = tag;
    two   = (len == 2);
    base  = (two && !rad) ? (a & ~1) : a;
    lenok = rad ? (len == 1 || (two && a % 2 == 0)) : (len == 1 || two);
    ref_word(rad, sec, base, d0, p_lw, p_bw, p_cw, r0, c0);
    r1 = 0; c1 = 0;
    if (two) ref_word(rad, sec, base + 1, d1, p_lw, p_bw, p_cw, r1, c1);
    rsn = !lenok ? 4 : (r0 != 0) ? r0 : (two && r1 != 0) ? r1 : 0;
    acc = (rsn == 0);
    if (!v) begin
      {e_valid, e_acc, e_mute, e_rsn, e_addr, e_two, e_d0, e_d1} = '0;
    end else begin
      e_valid = 1; e_acc = acc; e_mute = rad && len == 0; e_rsn = rsn[2:0];
      e_addr = base[9:0]; e_two = two;
      e_d0 = acc ? c0 : 16'h0;
      e_d1 = (acc && two) ? c1 : 16'h0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    rst = 1; req_valid = 0; req_radio = 0; req_secured = 0; req_addr = 0; req_len = 0;
    req_data0 = 0; req_data1 = 0; lock_word = 0; blk_word = 0; cfg_word = 0;
    repeat (3) @(negedge clk);
    check_now();                                     // R1 reset state
    rst = 0;
    apply("R1", 1, 0, 0, 0, 1, 16'h1234, 0);
    apply("R1", 0, 0, 0, 0, 1, 16'h1234, 0);
    // R5 radio block-lock command gated by enable bit
    p_bw = 16'h8000; p_cw = 16'h0000;
    apply("R5", 1, 1, 1, 9, 1, 16'h0001, 0);
    p_cw = 16'h0020;
    apply("R5", 1, 1, 1, 9, 1, 16'h0001, 0);
    // R4 host merge, bit 0 taken as written
    p_bw = 16'h8001;
    apply("R4", 1, 0, 0, 9, 1, 16'h0002, 0);
    // R3 block 0
    p_bw = 16'h0001; p_lw = 16'h0000;
    apply("R3", 1, 0, 0, 32, 1, 16'hAAAA, 0);
    apply("R3", 1, 1, 1, 32, 1, 16'hAAAA, 0);
    // R2 block geometry
    p_bw = 16'h0010;
    apply("R2", 1, 0, 0, 160, 1, 16'h5555, 0);
    apply("R2", 1, 0, 0, 159, 1, 16'h5555, 0);
    p_bw = 16'h8000;
    apply("R2", 1, 1, 0, 255, 1, 16'h5555, 0);
    p_bw = 16'hFFFF;
    apply("R2", 1, 1, 0, 256, 1, 16'h5555, 0);
    apply("R2", 1, 0, 0, 543, 1, 16'h5555, 0);
    // R6 bank lock pairs on the user area
    p_bw = 0; p_lw = 16'h0200;
    apply("R6", 1, 1, 0, 300, 1, 16'h0F0F, 0);
    apply("R6", 1, 1, 1, 300, 1, 16'h0F0F, 0);
    p_lw = 16'h0300;
    apply("R6", 1, 1, 1, 300, 1, 16'h0F0F, 0);
    apply("R6", 1, 0, 0, 300, 1, 16'h0F0F, 0);
    p_lw = 16'h0100;
    apply("R6", 1, 1, 0, 300, 1, 16'h0F0F, 0);
    p_lw = 16'hC000;
    apply("R6", 1, 1, 1, 1, 1, 16'h0F0F, 0);
    // R7 device-address lock
    p_lw = 16'h0082;
    apply("R7", 1, 0, 0, 4, 1, 16'h0001, 0);
    p_lw = 16'h0002;
    apply("R7", 1, 0, 0, 4, 1, 16'h0001, 0);
    // R8 read-only regions
    apply("R8", 1, 0, 0, 5, 1, 16'hFFFF, 0);
    apply("R8", 1, 0, 0, 22, 1, 16'hFFFF, 0);
    apply("R8", 1, 1, 1, 600, 1, 16'hFFFF, 0);
    apply("R8", 1, 1, 1, 4, 1, 16'hFFFF, 0);
    // R9 radio config write keeps host-only bits
    p_lw = 0; p_cw = 16'h0027;
    apply("R9", 1, 1, 0, 10, 1, 16'hFFD8, 0);
    // R10 radio lengths
    apply("R10", 1, 1, 1, 40, 0, 16'h1111, 0);
    apply("R10", 1, 1, 1, 41, 2, 16'h1111, 16'h2222);
    apply("R10", 1, 1, 1, 40, 3, 16'h1111, 16'h2222);
    apply("R10", 1, 1, 1, 12, 2, 16'h1111, 16'h2222);
    // R11 host lengths
    apply("R11", 1, 0, 0, 13, 2, 16'h3333, 16'h4444);
    apply("R11", 1, 0, 0, 13, 0, 16'h3333, 0);
    apply("R11", 1, 0, 0, 13, 3, 16'h3333, 0);
    // R12 two-word pairs
    apply("R12", 1, 0, 0, 4, 2, 16'h0000, 16'h0000);
    p_lw = 16'h0C00;
    apply("R12", 1, 1, 1, 10, 2, 16'h0018, 16'h7777);
    apply("R12", 1, 1, 1, 8, 2, 16'h0018, 16'h7777);
    for (int i = 0; i < 400; i++) begin
      int a, len;
      case ($urandom_range(0, 3))
        0: a = $urandom_range(0, 1023);
        1: a = $urandom_range(0, 40);
        default: a = $urandom_range(32, 300);
      endcase
      len = ($urandom_range(0, 5) < 4) ? $urandom_range(1, 2) : $urandom_range(0, 7);
      p_lw = 16'($urandom); p_bw = 16'($urandom); p_cw = 16'($urandom);
      apply("R12", $urandom_range(0, 9) != 0, 1'($urandom), 1'($urandom), a, len,
            16'($urandom), 16'($urandom));
    end
    apply("R1", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    finish_run();
  end
endmodule